// File: doc/BRIEF.md
# Tag-Matched Custom Operation Unit

This block is a reconfigurable functional unit that sits beside a processor's register file and keeps up to four custom operations resident at once. Every resident slot carries an operation tag, a mask of the shadowed registers it reads, a reduction function and a fixed evaluation latency. The unit keeps its own shadow copy of eight register-file entries. Each entry is stamped with the cycle in which it was last written, so the slot logic is always evaluating on the latest values.

When the processor issues a custom operation, the unit looks the tag up across all slots. On a hit it holds the processor stalled until every masked operand has settled for the slot's latency, then gives the result for exactly one cycle. On a miss it asks an external loader for the slot's configuration through a request/acknowledge pair. The slot it replaces is the least recently used one. After the acknowledge it proceeds as on a hit. Operations may read any number of the shadowed registers. Operands that were written long before the issue cost nothing extra, and only late-written operands lengthen the stall.

Top module: `rfu_unit`

## Requirements
- R1: After reset, stall, res_valid and rl_req are low, res_data is zero, and every slot is empty, so the first issue of any tag misses.
- R2: A write (wr_en high at a clock edge) stores wr_data into shadow register wr_idx and stamps it with that cycle; later results use the new value.
- R3: An issue whose tag matches a resident slot raises no reload request and is served from that slot.
- R4: With issue accepted in cycle t, the result appears in the first cycle c with c >= t+1 and c >= s+L+1, where L is the slot latency and s is the latest write cycle over the slot's masked registers, counting writes made while waiting. A write in the result cycle itself takes effect after it.
- R5: The result reduces the masked shadow registers, any number of them, with the slot's function code: 0 sum modulo 2^DATA_W, 1 bitwise XOR, 2 bitwise AND (all ones for an empty mask), 3 bitwise OR. The reduction uses the values present in the result cycle. res_data is zero whenever res_valid is low.
- R6: On a miss in cycle t, rl_req rises in cycle t+1 with rl_tag equal to the issued tag and rl_slot naming the victim. All three hold until the cycle in which rl_ack is high.
- R7: rl_ack loads the victim slot with rl_tag, rl_mask, rl_lat and rl_op. From the next cycle the operation completes by the R4 rule.
- R8: The victim is the least recently used slot. After reset slot 0 is oldest, then 1, 2 and 3. A slot becomes most recent when it is hit at issue or filled by a reload.
- R9: res_valid lasts exactly one cycle per accepted issue. stall is high in every cycle from the one after the issue up to the result cycle, and low in the result cycle and while idle.
- R10: issue_valid is ignored whenever the unit is busy (stall or res_valid high). It neither starts a lookup nor causes a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_idx | input | 3 | Shadow register index |
| wr_data | input | 16 | Value written to the shadow register |
| issue_valid | input | 1 | Custom operation issued this cycle |
| issue_tag | input | 4 | Tag of the issued operation |
| stall | output | 1 | Processor must hold |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 16 | Operation result |
| rl_req | output | 1 | Slot reload requested |
| rl_tag | output | 4 | Tag that must be loaded |
| rl_slot | output | 2 | Slot being replaced |
| rl_ack | input | 1 | Configuration present on rl_mask, rl_lat, rl_op |
| rl_mask | input | 8 | Registers the loaded operation reads |
| rl_lat | input | 3 | Evaluation latency of the loaded operation |
| rl_op | input | 2 | Reduction function code of the loaded operation |

## Verification
The assertions assume that the loader raises rl_ack only while rl_req is high. They also assume that the cycle counter never wraps within a run, and that wr_idx addresses an existing register. The stimulus acknowledges only after it has seen the request and keeps runs far shorter than the counter range. It drives issue_valid during busy cycles only on purpose, to exercise the ignore rule. It also writes shadow registers in the issue cycle and during the wait, so that the stall has to stretch.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

  typedef enum logic [1:0] {
    OP_SUM = 2'd0,
    OP_XOR = 2'd1,
    OP_AND = 2'd2,
    OP_OR  = 2'd3
  } rfu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RELOAD = 2'd1,
    ST_WAIT   = 2'd2
  } rfu_state_e;

endpackage

// File: rtl/rfu_operand_track.sv
module rfu_operand_track #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int CYC_W  = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [$clog2(NREG)-1:0]            wr_idx,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [CYC_W-1:0]                   cyc,
  output logic [NREG-1:0][DATA_W-1:0]        shadow,
  output logic [NREG-1:0][CYC_W-1:0]         stamp
);
  localparam int IW = $clog2(NREG);

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + CYC_W'(1);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit_w;
    assign hit_w = wr_en && (wr_idx == IW'(r));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[r] <= '0;
        stamp[r]  <= '0;
      end else if (hit_w) begin
        shadow[r] <= wr_data;
        stamp[r]  <= cyc;
      end
    end
  end

  // R2
  stamp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stamp[$past(wr_idx)] == $past(cyc)) && (shadow[$past(wr_idx)] == $past(wr_data)));

  // R4
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cyc == $past(cyc) + CYC_W'(1));

endmodule

// File: rtl/rfu_tag_table.sv
module rfu_tag_table #(
  parameter int NSLOT = 4,
  parameter int NREG  = 8,
  parameter int TAG_W = 4,
  parameter int LAT_W = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [TAG_W-1:0]                      look_tag,
  output logic [NSLOT-1:0]                      match_vec,
  output logic                                  hit,
  output logic [$clog2(NSLOT)-1:0]              hit_slot,
  output logic [$clog2(NSLOT)-1:0]              victim_slot,
  input  logic                                  fill_en,
  input  logic [$clog2(NSLOT)-1:0]              fill_slot,
  input  logic [TAG_W-1:0]                      fill_tag,
  input  logic [NREG-1:0]                       fill_mask,
  input  logic [LAT_W-1:0]                      fill_lat,
  input  logic [1:0]                            fill_op,
  input  logic                                  touch_en,
  input  logic [$clog2(NSLOT)-1:0]              touch_slot,
  output logic [NSLOT-1:0][NREG-1:0]            slot_mask,
  output logic [NSLOT-1:0][LAT_W-1:0]           slot_lat,
  output logic [NSLOT-1:0][1:0]                 slot_op
);
  localparam int SW = $clog2(NSLOT);
  localparam logic [SW-1:0] OLDEST = SW'(NSLOT - 1);

  logic [NSLOT-1:0]            slot_valid;
  logic [NSLOT-1:0][TAG_W-1:0] slot_tag;
  logic [NSLOT-1:0][SW-1:0]    rank;
  logic [NSLOT-1:0]            rank_seen;
  logic [SW-1:0]               touch_rank;

  assign touch_rank = rank[touch_slot];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic fill_here;
    assign fill_here    = fill_en && (fill_slot == SW'(s));
    assign match_vec[s] = slot_valid[s] && (slot_tag[s] == look_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_valid[s] <= 1'b0;
        slot_tag[s]   <= '0;
        slot_mask[s]  <= '0;
        slot_lat[s]   <= '0;
        slot_op[s]    <= '0;
      end else if (fill_here) begin
        slot_valid[s] <= 1'b1;
        slot_tag[s]   <= fill_tag;
        slot_mask[s]  <= fill_mask;
        slot_lat[s]   <= fill_lat;
        slot_op[s]    <= fill_op;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank[s] <= SW'(NSLOT - 1 - s);
      end else if (touch_en) begin
        if (touch_slot == SW'(s))     rank[s] <= '0;
        else if (rank[s] < touch_rank) rank[s] <= rank[s] + SW'(1);
      end
    end
  end

  always_comb begin
    hit         = 1'b0;
    hit_slot    = '0;
    victim_slot = '0;
    rank_seen   = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (match_vec[s]) begin
        hit      = 1'b1;
        hit_slot = SW'(s);
      end
      if (rank[s] == OLDEST) victim_slot = SW'(s);
      rank_seen[rank[s]] = 1'b1;
    end
  end

  // R3
  match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R8
  lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rank_seen) == NSLOT);

  // R8
  touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> rank[$past(touch_slot)] == '0);

  // R7
  fill_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> slot_valid[$past(fill_slot)] && (slot_tag[$past(fill_slot)] == $past(fill_tag))
               && (slot_mask[$past(fill_slot)] == $past(fill_mask)));

endmodule

// File: rtl/rfu_slot_eval.sv
module rfu_slot_eval #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int CYC_W  = 32,
  parameter int LAT_W  = 3
) (
  input  logic [NREG-1:0][DATA_W-1:0] shadow,
  input  logic [NREG-1:0][CYC_W-1:0]  stamp,
  input  logic [CYC_W-1:0]            cyc,
  input  logic [NREG-1:0]             mask,
  input  logic [LAT_W-1:0]            lat,
  input  logic [1:0]                  op,
  output logic [DATA_W-1:0]           result,
  output logic [CYC_W-1:0]            latest,
  output logic                        ready
);
  import rfu_pkg::*;

  function automatic logic [DATA_W-1:0] seed_of(rfu_op_e f);
    return (f == OP_AND) ? '1 : '0;
  endfunction

  function automatic logic [DATA_W-1:0] fold(rfu_op_e f, logic [DATA_W-1:0] acc,
                                             logic [DATA_W-1:0] x);
    case (f)
      OP_SUM:  return acc + x;
      OP_XOR:  return acc ^ x;
      OP_AND:  return acc & x;
      default: return acc | x;
    endcase
  endfunction

  function automatic logic [CYC_W-1:0] settle_cycle(logic [CYC_W-1:0] last_wr,
                                                    logic [LAT_W-1:0] l);
    return last_wr + CYC_W'(l) + CYC_W'(1);
  endfunction

  rfu_op_e fsel;
  assign fsel = rfu_op_e'(op);

  always_comb begin
    result = seed_of(fsel);
    latest = '0;
    for (int r = 0; r < NREG; r++) begin
      if (mask[r]) begin
        result = fold(fsel, result, shadow[r]);
        if (stamp[r] > latest) latest = stamp[r];
      end
    end
  end

  assign ready = (cyc >= settle_cycle(latest, lat));

endmodule

// File: rtl/rfu_unit.sv
module rfu_unit #(
  parameter int NSLOT  = 4,
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int LAT_W  = 3,
  parameter int CYC_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NREG)-1:0]    wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       issue_valid,
  input  logic [TAG_W-1:0]           issue_tag,
  output logic                       stall,
  output logic                       res_valid,
  output logic [DATA_W-1:0]          res_data,
  output logic                       rl_req,
  output logic [TAG_W-1:0]           rl_tag,
  output logic [$clog2(NSLOT)-1:0]   rl_slot,
  input  logic                       rl_ack,
  input  logic [NREG-1:0]            rl_mask,
  input  logic [LAT_W-1:0]           rl_lat,
  input  logic [1:0]                 rl_op
);
  import rfu_pkg::*;

  localparam int SW = $clog2(NSLOT);

  rfu_state_e                  state;
  logic [SW-1:0]               sel_q;
  logic [TAG_W-1:0]            tag_q;

  logic [CYC_W-1:0]            cyc;
  logic [NREG-1:0][DATA_W-1:0] shadow;
  logic [NREG-1:0][CYC_W-1:0]  stamp;

  logic [NSLOT-1:0]            match_vec;
  logic                        hit;
  logic [SW-1:0]               hit_slot;
  logic [SW-1:0]               victim_slot;
  logic [NSLOT-1:0][NREG-1:0]  slot_mask;
  logic [NSLOT-1:0][LAT_W-1:0] slot_lat;
  logic [NSLOT-1:0][1:0]       slot_op;

  logic                        lookup_hit;
  logic                        lookup_miss;
  logic                        fill_evt;
  logic                        done_evt;
  logic                        touch_en;
  logic [SW-1:0]               touch_slot;
  logic [DATA_W-1:0]           eval_result;
  logic [CYC_W-1:0]            eval_latest;
  logic                        eval_ready;

  rfu_operand_track #(.NREG(NREG), .DATA_W(DATA_W), .CYC_W(CYC_W)) u_track (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cyc(cyc), .shadow(shadow), .stamp(stamp)
  );

  rfu_tag_table #(.NSLOT(NSLOT), .NREG(NREG), .TAG_W(TAG_W), .LAT_W(LAT_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .look_tag(issue_tag), .match_vec(match_vec),
    .hit(hit), .hit_slot(hit_slot), .victim_slot(victim_slot),
    .fill_en(fill_evt), .fill_slot(sel_q), .fill_tag(tag_q),
    .fill_mask(rl_mask), .fill_lat(rl_lat), .fill_op(rl_op),
    .touch_en(touch_en), .touch_slot(touch_slot),
    .slot_mask(slot_mask), .slot_lat(slot_lat), .slot_op(slot_op)
  );

  rfu_slot_eval #(.NREG(NREG), .DATA_W(DATA_W), .CYC_W(CYC_W), .LAT_W(LAT_W)) u_eval (
    .shadow(shadow), .stamp(stamp), .cyc(cyc),
    .mask(slot_mask[sel_q]), .lat(slot_lat[sel_q]), .op(slot_op[sel_q]),
    .result(eval_result), .latest(eval_latest), .ready(eval_ready)
  );

  assign lookup_hit  = (state == ST_IDLE) && issue_valid && hit;
  assign lookup_miss = (state == ST_IDLE) && issue_valid && !hit;
  assign fill_evt    = (state == ST_RELOAD) && rl_ack;
  assign done_evt    = (state == ST_WAIT) && eval_ready;
  assign touch_en    = lookup_hit || fill_evt;
  assign touch_slot  = lookup_hit ? hit_slot : sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sel_q <= '0;
      tag_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (lookup_hit) begin
            sel_q <= hit_slot;
            state <= ST_WAIT;
          end else if (lookup_miss) begin
            sel_q <= victim_slot;
            tag_q <= issue_tag;
            state <= ST_RELOAD;
          end
        end
        ST_RELOAD: if (fill_evt) state <= ST_WAIT;
        ST_WAIT:   if (done_evt) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign stall     = (state != ST_IDLE) && !done_evt;
  assign res_valid = done_evt;
  assign res_data  = done_evt ? eval_result : '0;
  assign rl_req    = (state == ST_RELOAD);
  assign rl_tag    = tag_q;
  assign rl_slot   = sel_q;

  // R9
  res_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> res_valid);

  // R6
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_req && !rl_ack) |=> rl_req && $stable(rl_tag) && $stable(rl_slot));

  // R6
  miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_miss |=> rl_req && (rl_tag == $past(issue_tag)));

  // R4
  not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cyc > eval_latest + CYC_W'(slot_lat[sel_q]));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rl_req) |=> !rl_req);

endmodule

// File: tb/rfu_unit_bench.sv
module rfu_unit_bench;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        issue_valid = 1'b0;
  logic [3:0]  issue_tag = '0;
  logic        stall, res_valid, rl_req;
  logic [15:0] res_data;
  logic [3:0]  rl_tag;
  logic [1:0]  rl_slot;
  logic        rl_ack = 1'b0;
  logic [7:0]  rl_mask = '0;
  logic [2:0]  rl_lat = '0;
  logic [1:0]  rl_op = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  rfu_unit u_rfu_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .issue_valid(issue_valid), .issue_tag(issue_tag), .stall(stall),
    .res_valid(res_valid), .res_data(res_data), .rl_req(rl_req), .rl_tag(rl_tag),
    .rl_slot(rl_slot), .rl_ack(rl_ack), .rl_mask(rl_mask), .rl_lat(rl_lat), .rl_op(rl_op)
  );

  always #(PER/2) clk = ~clk;

  // reference model state
  int          m_cyc = 0;
  logic [15:0] m_reg [8];
  int          m_stamp [8];
  bit          s_valid [4];
  int          s_tag [4];
  logic [7:0]  s_mask [4];
  int          s_lat [4];
  int          s_op [4];
  int          lru [$];
  int          m_st = 0;
  int          m_sel = 0;
  int          m_tag = 0;

  function automatic logic [7:0] lib_mask(int t);
    logic [7:0] p;
    p = 8'((t * 91) & 255);
    return p ^ 8'hA3;
  endfunction

  function automatic int lib_lat(int t); return (t % 4) + 1; endfunction
  function automatic int lib_op(int t);  return t % 4;       endfunction

  function automatic logic [15:0] m_eval(int s);
    logic [15:0] acc;
    acc = (s_op[s] == 2) ? 16'hFFFF : 16'h0000;
    for (int r = 0; r < 8; r++)
      if (s_mask[s][r]) begin
        if (s_op[s] == 0)      acc = acc + m_reg[r];
        else if (s_op[s] == 1) acc = acc ^ m_reg[r];
        else if (s_op[s] == 2) acc = acc & m_reg[r];
        else                   acc = acc | m_reg[r];
      end
    return acc;
  endfunction

  function automatic bit m_ready(int s);
    int last;
    last = 0;
    for (int r = 0; r < 8; r++)
      if (s_mask[s][r] && m_stamp[r] > last) last = m_stamp[r];
    return m_cyc >= last + s_lat[s] + 1;
  endfunction

  function automatic int m_find(int t);
    for (int s = 0; s < 4; s++) if (s_valid[s] && s_tag[s] == t) return s;
    return -1;
  endfunction

  task automatic m_touch(int s);
    for (int i = 0; i < lru.size(); i++)
      if (lru[i] == s) begin lru.delete(i); break; end
    lru.push_front(s);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, m_cyc);
    end
  endtask

  task automatic step();
    bit e_done, e_stall;
    logic [15:0] e_res;
    int f;
    #1;
    e_done  = (m_st == 2) && m_ready(m_sel);
    e_stall = (m_st != 0) && !e_done;
    e_res   = e_done ? m_eval(m_sel) : 16'h0;
    chk(res_valid == e_done, "R9 res_valid", int'(res_valid), int'(e_done));
    chk(stall == e_stall, "R9 stall", int'(stall), int'(e_stall));
    chk(res_data == e_res, "R5 res_data", int'(res_data), int'(e_res));
    chk(rl_req == (m_st == 1), "R6 rl_req", int'(rl_req), int'(m_st == 1));
    if (m_st == 1) begin
      chk(int'(rl_tag) == m_tag, "R6 rl_tag", int'(rl_tag), m_tag);
      chk(int'(rl_slot) == m_sel, "R8 rl_slot", int'(rl_slot), m_sel);
    end
    @(posedge clk);
    if (m_st == 2) begin
      if (e_done) m_st = 0;
    end else if (m_st == 1) begin
      if (rl_ack) begin
        s_valid[m_sel] = 1'b1;
        s_tag[m_sel]   = m_tag;
        s_mask[m_sel]  = rl_mask;
        s_lat[m_sel]   = int'(rl_lat);
        s_op[m_sel]    = int'(rl_op);
        m_touch(m_sel);
        m_st = 2;
      end
    end else if (issue_valid) begin
      f = m_find(int'(issue_tag));
      if (f >= 0) begin
        m_touch(f);
        m_sel = f;
        m_st  = 2;
      end else begin
        m_sel = lru[lru.size()-1];
        m_tag = int'(issue_tag);
        m_st  = 1;
      end
    end
    if (wr_en) begin
      m_reg[wr_idx]   = wr_data;
      m_stamp[wr_idx] = m_cyc;
    end
    m_cyc++;
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    wr_en = 1'b0; issue_valid = 1'b0; rl_ack = 1'b0;
  endtask

  // issue one operation and follow it to completion
  task automatic run_op(input int tag, input int ack_delay, input int late_idx,
                        input int mid_idx, input int busy_tag,
                        output int ncyc, output int nres, output bit saw_req,
                        output int req_slot, output logic [15:0] rdata);
    int reqcnt;
    reqcnt = 0; ncyc = -1; nres = 0; saw_req = 1'b0; req_slot = -1; rdata = '0;
    issue_valid = 1'b1;
    issue_tag   = 4'(tag);
    if (late_idx >= 0) begin
      wr_en = 1'b1; wr_idx = 3'(late_idx); wr_data = 16'(m_cyc * 313 + 7);
    end
    step();
    clear_inputs();
    for (int k = 1; k < 40; k++) begin
      if (k == 1 && busy_tag >= 0) begin
        issue_valid = 1'b1; issue_tag = 4'(busy_tag);
      end
      if (k == 1 && mid_idx >= 0) begin
        wr_en = 1'b1; wr_idx = 3'(mid_idx); wr_data = 16'(m_cyc * 171 + 3);
      end
      #1;
      if (rl_req) begin
        reqcnt++;
        saw_req  = 1'b1;
        req_slot = int'(rl_slot);
        if (reqcnt > ack_delay) begin
          rl_ack  = 1'b1;
          rl_mask = lib_mask(int'(rl_tag));
          rl_lat  = 3'(lib_lat(int'(rl_tag)));
          rl_op   = 2'(lib_op(int'(rl_tag)));
        end
      end
      if (res_valid) begin
        nres++;
        if (ncyc < 0) begin ncyc = k; rdata = res_data; end
      end
      step();
      clear_inputs();
      if (ncyc >= 0 && k >= ncyc + 2) break;
    end
  endtask

  initial begin
    int n, nr, rs;
    bit sr;
    logic [15:0] rd;
    for (int r = 0; r < 8; r++) begin m_reg[r] = '0; m_stamp[r] = 0; end
    for (int s = 0; s < 4; s++) begin
      s_valid[s] = 1'b0; s_tag[s] = 0; s_mask[s] = '0; s_lat[s] = 0; s_op[s] = 0;
    end
    lru = '{3, 2, 1, 0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(stall == 1'b0, "R1 stall", int'(stall), 0);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(rl_req == 1'b0, "R1 rl_req", int'(rl_req), 0);
    chk(res_data == 16'h0, "R1 res_data", int'(res_data), 0);

    // R2 load the shadow registers
    for (int r = 0; r < 8; r++) begin
      wr_en = 1'b1; wr_idx = 3'(r); wr_data = 16'(16'h1357 * (r + 1) + r);
      step();
    end
    clear_inputs();
    step();

    // tag 5: first issue misses (R1), fills slot 0 (R8), ack after 2 extra cycles (R7)
    run_op(5, 2, -1, -1, -1, n, nr, sr, rs, rd);
    chk(sr, "R1 first issue misses", int'(sr), 1);
    chk(rs == 0, "R8 first victim slot", rs, 0);
    chk(n == 4, "R7 latency after delayed ack", n, 4);

    // tag 5 again: hit, one cycle (R3, R4)
    run_op(5, 0, -1, -1, -1, n, nr, sr, rs, rd);
    chk(!sr, "R3 hit raises no reload", int'(sr), 0);
    chk(n == 1, "R4 early operands one cycle", n, 1);
    chk(rd == (16'(16'h1357*3+2) ^ 16'(16'h1357*6+5) ^ 16'(16'h1357*7+6)),
        "R5 three-input xor", int'(rd), 0);

    // late operand written in the issue cycle, latency 2 (R4, R2)
    run_op(5, 0, 2, -1, -1, n, nr, sr, rs, rd);
    chk(n == 3, "R4 late operand stretch", n, 3);

    // fill tags 6, 7, 8 into slots 1..3 (R8)
    run_op(6, 0, -1, -1, -1, n, nr, sr, rs, rd);
    chk(rs == 1, "R8 second victim", rs, 1);
    chk(n == 2, "R7 immediate ack latency", n, 2);
    run_op(7, 0, -1, -1, -1, n, nr, sr, rs, rd);
    chk(rs == 2, "R8 third victim", rs, 2);
    run_op(8, 0, -1, -1, -1, n, nr, sr, rs, rd);
    chk(rs == 3, "R8 fourth victim", rs, 3);

    // touch 5, then a new tag must evict slot 1 (tag 6)
    run_op(5, 0, -1, -1, -1, n, nr, sr, rs, rd);
    run_op(9, 1, -1, -1, -1, n, nr, sr, rs, rd);
    chk(rs == 1, "R8 least recent evicted", rs, 1);

    // issue while busy is ignored (R10): tag 7 latency 4 with late write
    run_op(7, 0, 1, -1, 12, n, nr, sr, rs, rd);
    chk(n == 5, "R4 latency four stretch", n, 5);
    chk(nr == 1, "R10 single result", nr, 1);
    chk(!sr, "R10 busy issue no reload", int'(sr), 0);

    // write during the wait extends the stall (R4): tag 8, latency 1
    run_op(8, 0, 0, 0, -1, n, nr, sr, rs, rd);
    chk(n == 3, "R4 write during wait", n, 3);

    // evicted tag 6 misses again (R3/R8)
    run_op(6, 0, -1, -1, -1, n, nr, sr, rs, rd);
    chk(sr, "R8 evicted tag reloads", int'(sr), 1);

    repeat (3) step();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule